// File: doc/BRIEF.md
# Second-Level Cache Tag Flush Controller

This block holds the tag state of a set-associative second-level cache and runs flush commands against it. Each way of each set records an address tag, a valid flag and an exclusive-ownership flag. A flush command gives a physical address, a byte length and two flags. The writeback flag asks for dirty data to go out, and the retain flag asks for the line to stay resident. The controller rounds the address down to a line boundary and walks the covered lines, one per clock. For each line it downgrades or invalidates the matching way, and when the command ends it returns a summary status.

An index-mode flush ignores the tag part of the address. It scans the ways of the addressed set from way 0 upward and acts on the first valid way only. It then reports the full line address rebuilt from that way and stops. When the cache is direct-mapped, the block also produces a pulse that clears a load-linked reservation whose line is removed. A separate fill port installs tags into the least-recently-used way of a set. Fills are taken only while the command port is ready, and this is how the surrounding logic, or a test, sets up cache contents.

Top module: `l2_flush_ctrl`

## Requirements
- R1: After reset every way is empty, `cmd_ready` is high, `busy`, `done` and `err` are low and `status` is 0, so a flush of any line reports status 0.
- R2: A legal command processes the lines from `cmd_addr` rounded down to a 32-byte boundary up to, but not including, that boundary plus `cmd_len`. It handles exactly ceil(`cmd_len`/32) lines, one per clock, with `busy` high once per line. A length of 0 touches nothing. `done` follows the last line by one cycle.
- R3: An exclusive hit with `cmd_retain`=1 clears only the exclusive flag, so the line stays resident as shared.
- R4: An exclusive hit with `cmd_retain`=0 removes the line.
- R5: A shared hit with `cmd_retain`=0 removes the line and makes its way the least-recently-used way of its set, so the next fill of that set picks it.
- R6: A shared hit with `cmd_retain`=1 leaves the line resident and unchanged.
- R7: `status` is valid with `done` and is held until the next `done`. It is 2 if any exclusive line was handled, otherwise 1 if any shared line was removed, otherwise 0.
- R8: A command with `cmd_retain`=1 and `cmd_wb`=0 is illegal. It raises `done` with `err`=1 and `status`=0 on the cycle after acceptance, processes no line, and changes no tag.
- R9: With `cmd_index`=1 the walk acts only on the lowest-numbered valid way of the first visited set that has one. It puts {that way's tag, set index, five zero bits} on `idx_addr` and ends the command at once.
- R10: With one way per set, each processed line whose 32-byte line address equals that of `rsv_addr` gives a one-cycle `rsv_clear` pulse, but only when `cmd_retain`=0. With more than one way `rsv_clear` never rises.
- R11: Each legal command with both `cmd_wb` and `cmd_retain` set gives exactly one one-cycle `dgrade_evt` pulse. Other commands give none.
- R12: `fill_way` shows the least-recently-used way of the set addressed by `fill_addr`. A fill installs the tag there with the exclusive flag from `fill_excl` and makes that way most recently used. In an empty 4-way set, successive fills land in ways 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Flush command present |
| cmd_ready | output | 1 | Controller idle, command taken this cycle |
| cmd_addr | input | ADDR_W (32) | Start physical address |
| cmd_len | input | LEN_W (16) | Byte length of the range |
| cmd_wb | input | 1 | Writeback requested |
| cmd_retain | input | 1 | Keep the line resident (downgrade) |
| cmd_index | input | 1 | Index-mode flush |
| busy | output | 1 | A line is processed this cycle |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 2 | 0 not found, 1 shared removed, 2 exclusive handled |
| err | output | 1 | Last command was illegal |
| idx_addr | output | ADDR_W (32) | Line address acted on by the last index flush |
| rsv_addr | input | ADDR_W (32) | Address held by the reservation register |
| rsv_clear | output | 1 | Reservation clear pulse |
| dgrade_evt | output | 1 | Downgrade command strobe |
| fill_valid | input | 1 | Install a tag |
| fill_addr | input | ADDR_W (32) | Address of the line to install |
| fill_excl | input | 1 | Install with exclusive ownership |
| fill_way | output | WAY_W (2) | Way a fill of `fill_addr` would use |

## Verification
The bench attacks the four outcomes of the exclusive/shared and retain matrix. It follows each flush with a second one, so that a downgrade done as an invalidate, or a retained shared line that was dropped, shows up as the wrong status. A range that starts mid-line and a neighbour line just past its end expose a walker that counts lines from the unaligned address or runs one line too far. A zero length exposes one that runs a line anyway. Index flushes over two populated sets catch a walker that does not stop, or that picks the wrong way or rebuilds the wrong address. A check of the victim way after a shared invalidate catches a way that was not demoted to least recently used. A direct-mapped second instance checks the reservation pulse against retain, and the 4-way instance checks that the pulse never rises there.

// File: rtl/l2fc_pkg.sv
// Package: shared encodings of the flush controller.
// Assumes: status codes are seen by software as 0/1/2.
package l2fc_pkg;
    typedef enum logic [1:0] {
        FST_NONE   = 2'd0,
        FST_SHARED = 2'd1,
        FST_EXCL   = 2'd2
    } flush_stat_e;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_WALK = 2'd1,
        WK_FIN  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/l2fc_tag_store.sv
// Tag store: valid, exclusive flag and tag for every way of every set.
// One full set is read combinationally. Fill and flush updates are written at the clock.
// Assumes: fill and flush update never target the same entry in one cycle.
module l2fc_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 64,
    parameter int TAG_W = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [WAYS-1:0]       rd_vld,
    output logic [WAYS-1:0]       rd_exc,
    output logic [WAYS*TAG_W-1:0] rd_tag,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  fill_excl,
    input  logic                  upd_en,
    input  logic [IDX_W-1:0]      upd_idx,
    input  logic [WAY_W-1:0]      upd_way,
    input  logic                  upd_inval
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic             vld_q [SETS][WAYS];
    logic             exc_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];

    // Read every way of the selected set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_vld[w]                  = vld_q[rd_idx][w];
            rd_exc[w]                  = exc_q[rd_idx][w];
            rd_tag[w*TAG_W +: TAG_W]   = tag_q[rd_idx][w];
        end
    end

    // Apply fills and flush actions, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    exc_q[s][w] <= 1'b0;
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            if (fill_en) begin
                vld_q[fill_idx][fill_way] <= 1'b1;
                exc_q[fill_idx][fill_way] <= fill_excl;
                tag_q[fill_idx][fill_way] <= fill_tag;
            end
            if (upd_en) begin
                exc_q[upd_idx][upd_way] <= 1'b0;
                if (upd_inval) vld_q[upd_idx][upd_way] <= 1'b0;
            end
        end
    end

    // Record the last flush action for the checks below.
    logic             ck_v, ck_inv;
    logic [IDX_W-1:0] ck_idx;
    logic [WAY_W-1:0] ck_way;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_v <= 1'b0; ck_inv <= 1'b0; ck_idx <= '0; ck_way <= '0;
        end else begin
            ck_v <= upd_en; ck_inv <= upd_inval; ck_idx <= upd_idx; ck_way <= upd_way;
        end
    end

    // R4 and R5: an invalidating action leaves the way empty.
    a_r4_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_v && ck_inv) |-> !vld_q[ck_idx][ck_way]);
    // R3: a downgrade keeps the line and drops ownership.
    a_r3_downgrade_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_v && !ck_inv) |-> (vld_q[ck_idx][ck_way] && !exc_q[ck_idx][ck_way]));
endmodule

// File: rtl/l2fc_lru.sv
// Replacement order: each way of each set holds an age, 0 = most recently used.
// A touch makes a way youngest. A demote makes it oldest. The victim is the oldest way.
// Assumes: touch and demote never hit the same set in one cycle.
module l2fc_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             demote_en,
    input  logic [IDX_W-1:0] demote_idx,
    input  logic [WAY_W-1:0] demote_way,
    input  logic [IDX_W-1:0] vic_idx,
    output logic [WAY_W-1:0] vic_way
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    // Pick the oldest way of the queried set.
    always_comb begin
        vic_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[vic_idx][w] == OLDEST) vic_way = WAY_W'(w);
    end

    // Reorder ages on touch or demote, reset to way number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (touch_en && touch_idx == IDX_W'(s)) begin
                        if (WAY_W'(w) == touch_way)
                            age_q[s][w] <= '0;
                        else if (age_q[s][w] < age_q[s][touch_way])
                            age_q[s][w] <= age_q[s][w] + 1'b1;
                    end else if (demote_en && demote_idx == IDX_W'(s)) begin
                        if (WAY_W'(w) == demote_way)
                            age_q[s][w] <= OLDEST;
                        else if (age_q[s][w] > age_q[s][demote_way])
                            age_q[s][w] <= age_q[s][w] - 1'b1;
                    end
                end
            end
        end
    end

    // Record last touch and demote for the checks below.
    logic             t_v, d_v;
    logic [IDX_W-1:0] t_idx, d_idx;
    logic [WAY_W-1:0] t_way, d_way;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_v <= 1'b0; d_v <= 1'b0; t_idx <= '0; d_idx <= '0; t_way <= '0; d_way <= '0;
        end else begin
            t_v <= touch_en; t_idx <= touch_idx; t_way <= touch_way;
            d_v <= demote_en && !(touch_en && touch_idx == demote_idx);
            d_idx <= demote_idx; d_way <= demote_way;
        end
    end

    // R12: a filled way becomes most recently used.
    a_r12_fill_youngest: assert property (@(posedge clk) disable iff (!rst_n)
        t_v |-> (age_q[t_idx][t_way] == '0));
    // R5: a removed shared way becomes the victim.
    a_r5_demote_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        d_v |-> (age_q[d_idx][d_way] == OLDEST));
endmodule

// File: rtl/l2fc_walker.sv
// Line walker: accepts a flush command, steps through its lines one per clock,
// decides each line's action from the tags read, and builds the final status.
// Assumes: at most one way of a set holds a given tag.
module l2fc_walker
    import l2fc_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic                  cmd_wb,
    input  logic                  cmd_retain,
    input  logic                  cmd_index,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            status,
    output logic                  err,
    output logic [ADDR_W-1:0]     idx_addr,
    input  logic [ADDR_W-1:0]     rsv_addr,
    output logic                  rsv_clear,
    output logic                  dgrade_evt,
    output logic [IDX_W-1:0]      rd_idx,
    input  logic [WAYS-1:0]       rd_vld,
    input  logic [WAYS-1:0]       rd_exc,
    input  logic [WAYS*TAG_W-1:0] rd_tag,
    output logic                  upd_en,
    output logic [WAY_W-1:0]      upd_way,
    output logic                  upd_inval,
    output logic                  demote_en
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = LEN_W - OFF_W + 1;

    walk_state_e       st_q;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  left_q;
    logic              ret_q, imode_q, saw_x_q, saw_s_q;
    flush_stat_e       stat_q;
    logic              err_q, rsv_q, dg_q;
    logic [ADDR_W-1:0] iaddr_q;

    logic [LEN_W:0]    len_up;
    logic [CNT_W-1:0]  nlines;
    logic              accept, illegal, walking;
    logic [TAG_W-1:0]  cur_tag, ftag;
    logic              found, fexc, act_x, act_s, stop, last, nx_x, nx_s;
    logic [WAY_W-1:0]  fway;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{cmd_addr[OFF_W-1:0], rsv_addr[OFF_W-1:0]};

    // Handshake and line count from the requested length.
    assign cmd_ready = (st_q == WK_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign illegal   = cmd_retain && !cmd_wb;
    assign len_up    = {1'b0, cmd_len} + (LEN_W+1)'(LINE_BYTES - 1);
    assign nlines    = len_up[LEN_W:OFF_W];
    assign walking   = (st_q == WK_WALK);
    assign rd_idx    = line_q[IDX_W-1:0];
    assign cur_tag   = line_q[LINE_W-1:IDX_W];

    // Find the acting way: tag match, or first valid way in index mode.
    always_comb begin
        found = 1'b0;
        fway  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && rd_vld[w] &&
                (imode_q || rd_tag[w*TAG_W +: TAG_W] == cur_tag)) begin
                found = 1'b1;
                fway  = WAY_W'(w);
            end
        end
        fexc = rd_exc[fway];
        ftag = rd_tag[fway*TAG_W +: TAG_W];
    end

    // Per-line action and end-of-walk decision.
    assign act_x     = walking && found && fexc;
    assign act_s     = walking && found && !fexc && !ret_q;
    assign upd_en    = act_x || act_s;
    assign upd_way   = fway;
    assign upd_inval = !(act_x && ret_q);
    assign demote_en = act_s;
    assign stop      = imode_q && found;
    assign last      = (left_q == CNT_W'(1)) || stop;
    assign nx_x      = saw_x_q || act_x;
    assign nx_s      = saw_s_q || act_s;

    // Command sequencing, status and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= WK_IDLE;
            line_q  <= '0;
            left_q  <= '0;
            ret_q   <= 1'b0;
            imode_q <= 1'b0;
            saw_x_q <= 1'b0;
            saw_s_q <= 1'b0;
            stat_q  <= FST_NONE;
            err_q   <= 1'b0;
            rsv_q   <= 1'b0;
            dg_q    <= 1'b0;
            iaddr_q <= '0;
        end else begin
            dg_q  <= accept && cmd_wb && cmd_retain;
            rsv_q <= (WAYS == 1) && walking && !ret_q &&
                     (line_q == rsv_addr[ADDR_W-1:OFF_W]);
            unique case (st_q)
                WK_IDLE: if (accept) begin
                    line_q  <= cmd_addr[ADDR_W-1:OFF_W];
                    left_q  <= nlines;
                    ret_q   <= cmd_retain;
                    imode_q <= cmd_index;
                    saw_x_q <= 1'b0;
                    saw_s_q <= 1'b0;
                    if (illegal || nlines == '0) begin
                        st_q   <= WK_FIN;
                        stat_q <= FST_NONE;
                        err_q  <= illegal;
                    end else begin
                        st_q <= WK_WALK;
                    end
                end
                WK_WALK: begin
                    line_q  <= line_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                    saw_x_q <= nx_x;
                    saw_s_q <= nx_s;
                    if (stop) iaddr_q <= {ftag, rd_idx, {OFF_W{1'b0}}};
                    if (last) begin
                        st_q   <= WK_FIN;
                        err_q  <= 1'b0;
                        stat_q <= nx_x ? FST_EXCL : (nx_s ? FST_SHARED : FST_NONE);
                    end
                end
                WK_FIN:  st_q <= WK_IDLE;
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign busy       = walking;
    assign done       = (st_q == WK_FIN);
    assign status     = stat_q;
    assign err        = err_q;
    assign idx_addr   = iaddr_q;
    assign rsv_clear  = rsv_q;
    assign dgrade_evt = dg_q;

    // R2: never walking while ready for a new command.
    a_r2_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);
    // R8: an illegal command ends at once with an error.
    a_r8_illegal_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_retain && !cmd_wb) |=> (done && err && status == 2'd0));
    // R7: status moves only when done is raised.
    a_r7_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));
    // R10: the reservation pulse only follows a walked line.
    a_r10_rsv_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_clear |-> $past(busy));
    // R11: a downgrade strobe follows a downgrade command.
    a_r11_dgrade_src: assert property (@(posedge clk) disable iff (!rst_n)
        dgrade_evt |-> $past(cmd_valid && cmd_ready && cmd_wb && cmd_retain));
endmodule

// File: rtl/l2_flush_ctrl.sv
// Top: second-level cache tag array with a range and index flush engine
// and a fill port that installs into the least-recently-used way.
// Assumes: fills are only accepted while the command port is idle.
module l2_flush_ctrl #(
    parameter int WAYS       = 4,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_wb,
    input  logic              cmd_retain,
    input  logic              cmd_index,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              err,
    output logic [ADDR_W-1:0] idx_addr,
    input  logic [ADDR_W-1:0] rsv_addr,
    output logic              rsv_clear,
    output logic              dgrade_evt,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_excl,
    output logic [WAY_W-1:0]  fill_way
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]      rd_idx, fill_idx;
    logic [TAG_W-1:0]      fill_tag;
    logic [WAYS-1:0]       rd_vld, rd_exc;
    logic [WAYS*TAG_W-1:0] rd_tag;
    logic                  upd_en, upd_inval, demote_en, fill_en;
    logic [WAY_W-1:0]      upd_way, vic_way;
    logic                  unused_fill_bits;

    // Fill address split and gating by idle.
    assign fill_idx         = fill_addr[OFF_W +: IDX_W];
    assign fill_tag         = fill_addr[ADDR_W-1 -: TAG_W];
    assign fill_en          = fill_valid && cmd_ready;
    assign fill_way         = vic_way;
    assign unused_fill_bits = ^fill_addr[OFF_W-1:0];

    l2fc_walker #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES),
                  .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_wb(cmd_wb), .cmd_retain(cmd_retain),
        .cmd_index(cmd_index), .busy(busy), .done(done), .status(status),
        .err(err), .idx_addr(idx_addr), .rsv_addr(rsv_addr),
        .rsv_clear(rsv_clear), .dgrade_evt(dgrade_evt),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_exc(rd_exc), .rd_tag(rd_tag),
        .upd_en(upd_en), .upd_way(upd_way), .upd_inval(upd_inval),
        .demote_en(demote_en)
    );

    l2fc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_exc(rd_exc), .rd_tag(rd_tag),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_way(vic_way),
        .fill_tag(fill_tag), .fill_excl(fill_excl),
        .upd_en(upd_en), .upd_idx(rd_idx), .upd_way(upd_way),
        .upd_inval(upd_inval)
    );

    l2fc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(fill_en), .touch_idx(fill_idx), .touch_way(vic_way),
        .demote_en(demote_en), .demote_idx(rd_idx), .demote_way(upd_way),
        .vic_idx(fill_idx), .vic_way(vic_way)
    );

    // R1: done and busy are never high together.
    a_r1_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: tb/l2_flush_ctrl_test.sv
module l2_flush_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_wb = 1'b0, cmd_retain = 1'b0, cmd_index = 1'b0;
    logic [31:0] cmd_addr = '0, rsv_addr = '0, fill_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        fill_valid = 1'b0, fill_excl = 1'b0;
    logic        cmd_ready, busy, done, err, rsv_clear, dgrade_evt;
    logic [1:0]  status, fill_way;
    logic [31:0] idx_addr;
    logic        rdy_dm, busy_dm, done_dm, err_dm, rsv_dm, dg_dm;
    logic [1:0]  stat_dm;
    logic [31:0] ia_dm;
    logic [0:0]  fw_dm;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int r_busy, r_dg, r_rsv, r_rsv_dm, r_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_flush_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wb(cmd_wb),
        .cmd_retain(cmd_retain), .cmd_index(cmd_index), .busy(busy), .done(done),
        .status(status), .err(err), .idx_addr(idx_addr), .rsv_addr(rsv_addr),
        .rsv_clear(rsv_clear), .dgrade_evt(dgrade_evt), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_excl(fill_excl), .fill_way(fill_way));

    l2_flush_ctrl #(.WAYS(1)) uut_dm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_dm),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wb(cmd_wb),
        .cmd_retain(cmd_retain), .cmd_index(cmd_index), .busy(busy_dm), .done(done_dm),
        .status(stat_dm), .err(err_dm), .idx_addr(ia_dm), .rsv_addr(rsv_addr),
        .rsv_clear(rsv_dm), .dgrade_evt(dg_dm), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_excl(fill_excl), .fill_way(fw_dm));

    function automatic logic [31:0] la(input int tag, input int set);
        return {tag[20:0], set[5:0], 5'b0};
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] a, input logic ex, input int exp_way, input string what);
        @(negedge clk);
        fill_addr = a; fill_excl = ex;
        #1 check(what, 32'(fill_way), 32'(exp_way));
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Issue one command and collect pulses until done.
    task automatic run_cmd(input logic [31:0] a, input int len, input logic wb,
                           input logic ret, input logic idx);
        @(negedge clk);
        cmd_addr = a; cmd_len = 16'(len); cmd_wb = wb; cmd_retain = ret; cmd_index = idx;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_busy = 0; r_dg = 0; r_rsv = 0; r_rsv_dm = 0; r_lat = 0;
        for (int k = 0; k < 5000; k++) begin
            r_busy += int'(busy); r_dg += int'(dgrade_evt);
            r_rsv += int'(rsv_clear); r_rsv_dm += int'(rsv_dm);
            if (done) break;
            r_lat++;
            @(negedge clk);
            if (k == 4999) begin
                n_chk++; n_fail++;
                $display("FAIL R2 command never finished actual=0 expected=1");
            end
        end
    endtask

    task automatic t_reset;
        check("R1 cmd_ready after reset", 32'(cmd_ready), 1);
        check("R1 busy low", 32'(busy), 0);
        check("R1 done low", 32'(done), 0);
        check("R1 status zero", 32'(status), 0);
        check("R1 err low", 32'(err), 0);
        run_cmd(la(3, 1), 32, 1, 0, 0);
        check("R1 empty cache not found", 32'(status), 0);
    endtask

    task automatic t_fill_order;
        do_fill(la(1, 5), 0, 3, "R12 first fill way");
        do_fill(la(2, 5), 0, 2, "R12 second fill way");
        do_fill(la(3, 5), 0, 1, "R12 third fill way");
        do_fill(la(4, 5), 0, 0, "R12 fourth fill way");
    endtask

    task automatic t_lru_demote;
        run_cmd(la(3, 5), 32, 0, 0, 0);
        check("R5 shared removed status", 32'(status), 1);
        @(negedge clk); fill_addr = la(9, 5);
        #1 check("R5 removed way is victim", 32'(fill_way), 1);
        do_fill(la(9, 5), 0, 1, "R5 refill lands in demoted way");
    endtask

    task automatic t_excl_downgrade;
        do_fill(la(40, 7), 1, 3, "R12 fill set7");
        run_cmd(la(40, 7) + 5, 32, 1, 1, 0);
        check("R3 exclusive downgrade status", 32'(status), 2);
        check("R11 one downgrade strobe", 32'(r_dg), 1);
        check("R2 unaligned start one line", 32'(r_busy), 1);
        run_cmd(la(40, 7), 32, 0, 0, 0);
        check("R3 line kept as shared", 32'(status), 1);
        check("R11 no strobe for invalidate", 32'(r_dg), 0);
    endtask

    task automatic t_excl_inval;
        do_fill(la(41, 8), 1, 3, "R12 fill set8");
        run_cmd(la(41, 8), 32, 1, 0, 0);
        check("R4 exclusive invalidate status", 32'(status), 2);
        run_cmd(la(41, 8), 32, 1, 0, 0);
        check("R4 line gone", 32'(status), 0);
    endtask

    task automatic t_shared_retain;
        do_fill(la(42, 9), 0, 3, "R12 fill set9");
        run_cmd(la(42, 9), 32, 1, 1, 0);
        check("R6 shared retain not found", 32'(status), 0);
        run_cmd(la(42, 9), 32, 1, 0, 0);
        check("R6 shared line still there", 32'(status), 1);
    endtask

    task automatic t_range;
        do_fill(la(50, 10), 0, 3, "R12 fill set10");
        do_fill(la(50, 11), 0, 3, "R12 fill set11");
        do_fill(la(50, 12), 1, 3, "R12 fill set12");
        do_fill(la(50, 13), 0, 3, "R12 fill set13");
        run_cmd(la(50, 10) + 7, 96, 1, 0, 0);
        check("R2 three lines walked", 32'(r_busy), 3);
        check("R7 exclusive dominates", 32'(status), 2);
        check("R2 done right after last line", 32'(r_lat), 3);
        run_cmd(la(50, 13), 0, 1, 0, 0);
        check("R2 zero length no line", 32'(r_busy), 0);
        check("R2 zero length status", 32'(status), 0);
        run_cmd(la(50, 13), 32, 1, 0, 0);
        check("R2 line past range untouched", 32'(status), 1);
        run_cmd(la(50, 11), 33, 1, 0, 0);
        check("R2 33 bytes is two lines", 32'(r_busy), 2);
        check("R2 range lines already removed", 32'(status), 0);
    endtask

    task automatic t_illegal;
        do_fill(la(60, 14), 1, 3, "R12 fill set14");
        run_cmd(la(60, 14), 32, 0, 1, 0);
        check("R8 err flagged", 32'(err), 1);
        check("R8 done next cycle", 32'(r_lat), 0);
        check("R8 no line walked", 32'(r_busy), 0);
        check("R8 status zero", 32'(status), 0);
        check("R11 illegal gives no strobe", 32'(r_dg), 0);
        run_cmd(la(60, 14), 32, 1, 0, 0);
        check("R8 line left exclusive", 32'(status), 2);
        check("R8 err cleared on legal", 32'(err), 0);
    endtask

    task automatic t_index;
        do_fill(la('h55, 20), 0, 3, "R12 fill set20 a");
        do_fill(la('h66, 20), 1, 2, "R12 fill set20 b");
        run_cmd(la(7, 20), 32, 1, 0, 1);
        check("R9 lowest valid way exclusive", 32'(status), 2);
        check("R9 rebuilt address", idx_addr, la('h66, 20));
        run_cmd(la(7, 20), 32, 1, 0, 1);
        check("R9 next valid way shared", 32'(status), 1);
        check("R9 rebuilt address second", idx_addr, la('h55, 20));
        run_cmd(la(7, 20), 32, 1, 0, 1);
        check("R9 empty set not found", 32'(status), 0);
        do_fill(la('h70, 22), 0, 3, "R12 fill set22");
        do_fill(la('h71, 23), 0, 3, "R12 fill set23");
        run_cmd(la(1, 22), 64, 0, 0, 1);
        check("R9 stops after first line", 32'(r_busy), 1);
        check("R9 address set22", idx_addr, la('h70, 22));
        run_cmd(la('h71, 23), 32, 0, 0, 0);
        check("R9 second set untouched", 32'(status), 1);
    endtask

    task automatic t_rsv;
        rsv_addr = la(7, 30) + 9;
        run_cmd(la(7, 30), 32, 1, 0, 0);
        check("R10 direct-mapped clear pulse", 32'(r_rsv_dm), 1);
        check("R10 no pulse with four ways", 32'(r_rsv), 0);
        run_cmd(la(7, 30), 32, 1, 1, 0);
        check("R10 retain gives no pulse", 32'(r_rsv_dm), 0);
        run_cmd(la(8, 30), 32, 1, 0, 0);
        check("R10 other line no pulse", 32'(r_rsv_dm), 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk) cyc = i;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_order();
        t_lru_demote();
        t_excl_downgrade();
        t_excl_inval();
        t_shared_retain();
        t_range();
        t_illegal();
        t_index();
        t_rsv();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule